// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects the interrupt requests that reach a DSP core and chooses the one that is serviced next. There are three external request lines, which are active low. Each line can be set to edge or level sensitivity. There is a set of internal event pulses, for example from the timer, the serial ports and the host port. There is also a powerdown request that cannot be masked. Every source has a fixed vector index, and a lower index wins. Index 0 is powerdown, indices 1 to N_EXT are the external lines, and the internal sources follow them.

A per-source mask register and a global enable decide which requests may be selected. Writing the mask closes selection for one cycle. The chosen vector goes to the sequencer with a request flag, and the flag is held until the sequencer acknowledges it. The acknowledge clears the latched request that belongs to that vector.

A three-state machine controls selection. In `ST_IDLE` the block is free to select. When a request is selectable, or when a mask write arrives with powerdown already latched, it moves to `ST_REQ`. When a mask write arrives with no powerdown latched, it moves to `ST_QUIET`. `ST_QUIET` lasts for the single blackout cycle. From there only a powerdown request can move the machine to `ST_REQ`. Another mask write keeps it in `ST_QUIET`, and otherwise it returns to `ST_IDLE`. `ST_REQ` holds the issued vector until an acknowledge arrives. It then moves to `ST_IDLE`, or to `ST_QUIET` if a mask write comes in the same cycle as the acknowledge.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, svc_req is 0, the global enable is on, and every mask bit is 0. Only powerdown can be serviced until the mask is written.
- R2: When several requests are selectable, the lowest vector index is issued. Vector 0 is powerdown, 1..3 are external lines 0..2, and 4..8 are internal pulses 0..4.
- R3: A source whose mask bit is 0 is never issued, but its request stays pending. It is issued once its bit is set. Bit j of mask_din enables vector j+1.
- R4: Powerdown is issued whatever the mask, the global enable and the blackout cycle say. A powerdown pulse given in the same cycle as a mask write is issued two clock edges after that cycle.
- R5: In the cycle after a mask write, no maskable vector is selected. A pending source that the write unmasks is issued at the third clock edge after the write cycle, exactly one cycle later than without the blackout.
- R6: A gie_clr pulse stops all maskable selection and leaves the mask register as it was. A gie_set pulse restores selection. If both pulses come in the same cycle, the clear wins.
- R7: A line with ext_edge_sel=1 latches a falling edge. The line may return high before the request is serviced. One falling edge gives exactly one service, and the acknowledge clears the latch.
- R8: A line with ext_edge_sel=0 is not latched. A low level that goes away before it is selectable is lost. A level held low is issued again after every acknowledge.
- R9: Once issued, svc_req and svc_vec stay stable until svc_ack. svc_ack clears the pending request of the issued vector, and an svc_ack given while no request is issued has no effect.
- R10: A one-cycle pulse on int_pulse or pwrdn_pulse stays pending until its vector is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq_n | input | N_EXT | External request lines, active low |
| ext_edge_sel | input | N_EXT | Per line: 1 selects edge sensitivity, 0 selects level sensitivity |
| int_pulse | input | N_INT | Internal event pulses |
| pwrdn_pulse | input | 1 | Powerdown request pulse |
| mask_we | input | 1 | Mask register write strobe |
| mask_din | input | NSRC-1 | New mask value; bit j enables vector j+1 |
| gie_set | input | 1 | Global enable pulse |
| gie_clr | input | 1 | Global disable pulse |
| svc_req | output | 1 | A vector is issued and waiting for acknowledge |
| svc_vec | output | VW | Issued vector index |
| svc_ack | input | 1 | Sequencer acknowledge |

## Verification
Two functions can fall in the same cycle: the mask-write blackout and the powerdown request. The bench applies a powerdown pulse in the same cycle as a mask write, with the global enable turned off. It expects vector 0 to appear during the blackout, at the exact edge given in R4. A second directed case unmasks a source that is already pending. There the bench checks that the request is still low one cycle after the blackout would have ended without the blackout rule, and high exactly one cycle later. An acknowledge given while nothing is issued is also placed against a held-back pending request, and the bench confirms that the request survives.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_QUIET = 2'd1,
        ST_REQ   = 2'd2
    } irq_state_e;
endpackage

// File: rtl/irq_ext_capture.sv
// Samples active-low external lines; edge lines latch a falling edge.
module irq_ext_capture #(
    parameter int N_EXT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] line_n,
    input  logic [N_EXT-1:0] edge_sel,
    input  logic [N_EXT-1:0] clr,
    output logic [N_EXT-1:0] req
);
    generate
        for (genvar g = 0; g < N_EXT; g++) begin : g_line
            logic smp_q;
            logic prev_q;
            logic latch_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    smp_q   <= 1'b1;
                    prev_q  <= 1'b1;
                    latch_q <= 1'b0;
                end else begin
                    smp_q  <= line_n[g];
                    prev_q <= smp_q;
                    if (edge_sel[g] && prev_q && !smp_q)
                        latch_q <= 1'b1;
                    else if (clr[g] || !edge_sel[g])
                        latch_q <= 1'b0;
                end
            end

            assign req[g] = edge_sel[g] ? latch_q : ~smp_q;
        end
    endgenerate
endmodule

// File: rtl/irq_pulse_latch.sv
// Holds single-cycle event pulses until cleared; a new pulse beats a clear.
module irq_pulse_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);
    logic [W-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr) | set;
    end

    assign pend = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
// Lowest set index wins.
module irq_prio_pick #(
    parameter int N  = 9,
    parameter int VW = 4
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [VW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i])
                idx = VW'(i);
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int N_EXT = 3,
    parameter int N_INT = 5,
    localparam int NSRC = 1 + N_EXT + N_INT,
    localparam int VW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXT-1:0]  ext_irq_n,
    input  logic [N_EXT-1:0]  ext_edge_sel,
    input  logic [N_INT-1:0]  int_pulse,
    input  logic              pwrdn_pulse,
    input  logic              mask_we,
    input  logic [NSRC-2:0]   mask_din,
    input  logic              gie_set,
    input  logic              gie_clr,
    output logic              svc_req,
    output logic [VW-1:0]     svc_vec,
    input  logic              svc_ack
);
    import irq_pkg::*;

    localparam int EXT_LO = 1;
    localparam int INT_LO = 1 + N_EXT;

    irq_state_e        state_q, state_d;
    logic [VW-1:0]     vec_q, vec_d;
    logic [NSRC-2:0]   mask_q;
    logic              gie_q;
    logic [NSRC-1:0]   pend;
    logic [NSRC-1:0]   cand;
    logic [NSRC-1:0]   clr_all;
    logic              ack_take;
    logic              allow;
    logic              any_sel;
    logic [VW-1:0]     sel_idx;
    logic [N_EXT-1:0]  ext_req;
    logic [N_INT-1:0]  int_pend;
    logic              pdn_pend;

    // Acknowledge decode: clear the latch of the issued vector
    assign ack_take = (state_q == ST_REQ) && svc_ack;

    always_comb begin
        for (int i = 0; i < NSRC; i++)
            clr_all[i] = ack_take && (vec_q == VW'(i));
    end

    irq_ext_capture #(.N_EXT(N_EXT)) ext_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_n   (ext_irq_n),
        .edge_sel (ext_edge_sel),
        .clr      (clr_all[INT_LO-1:EXT_LO]),
        .req      (ext_req)
    );

    irq_pulse_latch #(.W(N_INT)) int_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (int_pulse),
        .clr   (clr_all[NSRC-1:INT_LO]),
        .pend  (int_pend)
    );

    irq_pulse_latch #(.W(1)) pdn_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (pwrdn_pulse),
        .clr   (clr_all[0]),
        .pend  (pdn_pend)
    );

    assign pend = {int_pend, ext_req, pdn_pend};

    // Mask register and global enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            gie_q  <= 1'b1;
        end else begin
            if (mask_we)
                mask_q <= mask_din;
            if (gie_clr)
                gie_q <= 1'b0;
            else if (gie_set)
                gie_q <= 1'b1;
        end
    end

    // Gating: powerdown bypasses every gate
    assign allow = gie_q && (state_q != ST_QUIET);

    always_comb begin
        cand[0]        = pend[0];
        cand[NSRC-1:1] = pend[NSRC-1:1] & mask_q & {(NSRC-1){allow}};
    end

    irq_prio_pick #(.N(NSRC), .VW(VW)) pick_i (
        .req (cand),
        .any (any_sel),
        .idx (sel_idx)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        vec_d   = vec_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mask_we) begin
                    if (cand[0]) begin
                        state_d = ST_REQ;
                        vec_d   = '0;
                    end else begin
                        state_d = ST_QUIET;
                    end
                end else if (any_sel) begin
                    state_d = ST_REQ;
                    vec_d   = sel_idx;
                end
            end
            ST_QUIET: begin
                if (any_sel) begin
                    state_d = ST_REQ;
                    vec_d   = sel_idx;
                end else if (mask_we) begin
                    state_d = ST_QUIET;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_REQ: begin
                if (svc_ack)
                    state_d = mask_we ? ST_QUIET : ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            vec_q   <= vec_d;
        end
    end

    // Outputs
    always_comb begin
        svc_req = (state_q == ST_REQ);
        svc_vec = vec_q;
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NSRC = 9,
    parameter int VW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mask_we,
    input logic            svc_req,
    input logic            svc_ack,
    input logic            gie_q,
    input logic [VW-1:0]   svc_vec,
    input logic [NSRC-2:0] mask_q
);
    logic [NSRC-2:0] mask_prev;
    logic [NSRC-2:0] mask_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_prev <= '0;
        else
            mask_prev <= mask_q;
    end

    assign mask_sh = mask_prev >> (svc_vec - VW'(1));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && !svc_ack) |=> (svc_req && $stable(svc_vec)));

    // R5
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> !(svc_req && !$past(svc_req) && (svc_vec != '0)));

    // R6
    gie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie_q && !svc_req) |=> !(svc_req && (svc_vec != '0)));

    // R3
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && !$past(svc_req) && (svc_vec != '0)) |-> mask_sh[0]);

    // R2
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> (int'(svc_vec) < NSRC));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC), .VW(VW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (mask_we),
    .svc_req (svc_req),
    .svc_ack (svc_ack),
    .gie_q   (gie_q),
    .svc_vec (svc_vec),
    .mask_q  (mask_q)
);

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ext_irq_n = 3'b111;
    logic [2:0] ext_edge_sel = 3'b101;
    logic [4:0] int_pulse = '0;
    logic       pwrdn_pulse = 1'b0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_din = '0;
    logic       gie_set = 1'b0;
    logic       gie_clr = 1'b0;
    logic       svc_req;
    logic [3:0] svc_vec;
    logic       svc_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_prio_ctrl #(.N_EXT(3), .N_INT(5)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_irq_n    (ext_irq_n),
        .ext_edge_sel (ext_edge_sel),
        .int_pulse    (int_pulse),
        .pwrdn_pulse  (pwrdn_pulse),
        .mask_we      (mask_we),
        .mask_din     (mask_din),
        .gie_set      (gie_set),
        .gie_clr      (gie_clr),
        .svc_req      (svc_req),
        .svc_vec      (svc_vec),
        .svc_ack      (svc_ack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mask(input logic [7:0] m);
        mask_we = 1'b1; mask_din = m;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    task automatic set_gie(input bit on);
        if (on) gie_set = 1'b1; else gie_clr = 1'b1;
        @(negedge clk);
        gie_set = 1'b0; gie_clr = 1'b0;
    endtask

    task automatic pulse_int(input logic [4:0] bits);
        int_pulse = bits;
        @(negedge clk);
        int_pulse = '0;
    endtask

    task automatic do_ack();
        svc_ack = 1'b1;
        @(negedge clk);
        svc_ack = 1'b0;
    endtask

    task automatic expect_vec(input int maxc, input int vec, input string tag);
        for (int i = 0; i < maxc && !svc_req; i++) @(negedge clk);
        chk(svc_req && (int'(svc_vec) == vec), tag,
            svc_req ? int'(svc_vec) : -1, vec);
    endtask

    task automatic expect_quiet(input int n, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (svc_req) seen = 1'b1;
        end
        chk(!seen, tag, int'(seen), 0);
    endtask

    // R1 reset state, R5 blackout timing, R3 masking, R10 pulse latch
    task automatic t_reset_and_blackout();
        chk(svc_req == 1'b0, "R1 req after reset", int'(svc_req), 0);
        pulse_int(5'b00001);
        expect_quiet(6, "R1 reset mask holds vec4");
        mask_we = 1'b1; mask_din = 8'h08;
        @(negedge clk);
        mask_we = 1'b0;
        chk(!svc_req, "R5 first cycle after write", int'(svc_req), 0);
        @(negedge clk);
        chk(!svc_req, "R5 blackout cycle", int'(svc_req), 0);
        @(negedge clk);
        chk(svc_req && svc_vec == 4'd4, "R3 R10 unmasked pending issued",
            svc_req ? int'(svc_vec) : -1, 4);
        do_ack();
        expect_quiet(4, "R10 pulse cleared by ack");
    endtask

    // R2 priority, R6 global disable, R9 hold until ack
    task automatic t_priority();
        write_mask(8'hFF);
        step(2);
        set_gie(1'b0);
        pulse_int(5'b01010);
        expect_quiet(5, "R6 global disable holds off");
        set_gie(1'b1);
        expect_vec(6, 5, "R2 lowest index first");
        step(4);
        chk(svc_req && svc_vec == 4'd5, "R9 held without ack",
            svc_req ? int'(svc_vec) : -1, 5);
        do_ack();
        expect_vec(6, 7, "R2 next index after ack");
        do_ack();
        expect_quiet(4, "R2 nothing left");
    endtask

    // R9 stray ack
    task automatic t_stray_ack();
        set_gie(1'b0);
        pulse_int(5'b10000);
        step(2);
        do_ack();
        step(2);
        set_gie(1'b1);
        expect_vec(6, 8, "R9 idle ack ignored");
        do_ack();
        step(2);
    endtask

    // R4 powerdown during blackout with global disable
    task automatic t_pdn();
        set_gie(1'b0);
        mask_we = 1'b1; mask_din = 8'h00; pwrdn_pulse = 1'b1;
        @(negedge clk);
        mask_we = 1'b0; pwrdn_pulse = 1'b0;
        @(negedge clk);
        chk(svc_req && svc_vec == 4'd0, "R4 powerdown in blackout",
            svc_req ? int'(svc_vec) : -1, 0);
        do_ack();
        set_gie(1'b1);
        write_mask(8'hFF);
        step(3);
    endtask

    // R7 edge lines
    task automatic t_edge();
        ext_irq_n[0] = 1'b0;
        @(negedge clk);
        ext_irq_n[0] = 1'b1;
        expect_vec(6, 1, "R7 short edge latched");
        do_ack();
        expect_quiet(6, "R7 one service per edge");
        ext_irq_n[2] = 1'b0;
        expect_vec(6, 3, "R7 held-low edge line");
        do_ack();
        expect_quiet(6, "R7 held low no repeat");
        ext_irq_n[2] = 1'b1;
        step(2);
    endtask

    // R8 level lines
    task automatic t_level();
        set_gie(1'b0);
        ext_irq_n[1] = 1'b0;
        @(negedge clk);
        ext_irq_n[1] = 1'b1;
        step(3);
        set_gie(1'b1);
        expect_quiet(5, "R8 brief level lost");
        ext_irq_n[1] = 1'b0;
        expect_vec(6, 2, "R8 level issued");
        do_ack();
        expect_vec(6, 2, "R8 level reissued");
        ext_irq_n[1] = 1'b1;
        do_ack();
        expect_quiet(5, "R8 released level");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset_and_blackout();
        t_priority();
        t_stray_ack();
        t_pdn();
        t_edge();
        t_level();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule